// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. It copies a block of bytes from a source address to a destination address over a simple request/acknowledge memory bus. Software loads a source address, a destination address, a byte count and a control word through a small register port. It then starts the channel either by setting a start bit in the control word or by letting a peripheral request line trigger it. Each transfer unit reads from the source at the source access size and then writes to the destination at the destination access size. Sizes of one, two or four bytes can be mixed on the two sides.

In continuous mode one request drains the whole byte count. In cycle-steal mode each request moves exactly one unit. An auto-align option forces address stepping on one side, whatever its increment bit says. The channel checks its configuration each time it is activated. A bad setup raises an error flag instead of moving data. Completion and errors are reported in a status register and can drive an interrupt line.

Top module: `dma_xfer_chan`

## Requirements
- R1: Register addresses are 0 source address, 1 destination address, 2 byte count, 3 control and 4 status. All registers read as zero after reset. In the control word only bits 31 (irq enable), 30 (peripheral enable), 29 (cycle steal), 28 (auto-align), 22 (source increment), 21:20 (source size), 19 (destination increment) and 18:17 (destination size) are stored; every other bit reads 0, including the write-only start bit 16. Status bit 0 is done, bit 1 is configuration error and bit 2 is busy.
- R2: Size code 00 means 4 bytes, 01 means 1 byte and 10 means 2 bytes. bus_size carries the source code on reads and the destination code on writes.
- R3: With source increment at 0, the source address register does not change. With it at 1, the register advances by the source byte size after every acknowledged read.
- R4: The destination address register follows the same rule after every acknowledged write, using the destination increment bit and the destination byte size.
- R5: One transfer unit is max(source bytes, destination bytes). It is made of unit/source-bytes reads followed by unit/destination-bytes writes. The unit's bytes are packed little-endian: read k fills unit bytes k*size upward, and each bus beat uses its low bytes. The byte count drops by the unit size when the last write of a unit is acknowledged.
- R6: In continuous mode (cycle steal 0), one request runs units until the count reaches 0. Done is then set and the channel goes idle.
- R7: In cycle-steal mode, each accepted request runs exactly one unit. Done is set when that unit brings the count to 0.
- R8: periph_req is ignored while the peripheral enable is 0. Writing the control word with bit 16 set always counts as a request.
- R9: A start write and periph_req in the same cycle form one request.
- R10: With auto-align set, the source side is the aligned side if source bytes >= destination bytes; otherwise the destination side is. The aligned side's address steps by its size even when its increment bit is 0. The alignment checks of R11 are skipped.
- R11: At activation, the configuration-error status is set and no bus cycle occurs if any of these holds: a size field is 11; the count is 0; the count is not a multiple of the unit; or, with auto-align off, an address is not a multiple of its side's size. The address and count registers then keep their values.
- R12: While done or configuration error is set, requests are refused. Writing status with bit 0 at 1 clears both flags.
- R13: irq equals irq-enable AND (done OR configuration error).
- R14: bus_req, bus_we, bus_addr, bus_size and bus_wdata hold steady until bus_ack. Register writes to addresses 0 to 3 are ignored while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, low bytes used |
| bus_rdata | input | 32 | Read data, low bytes used |
| bus_ack | input | 1 | Bus cycle complete |
| irq | output | 1 | Interrupt request |

## Verification
The properties check on every cycle that the bus holds steady until acknowledged, that the read size follows the source size code, and that source address stepping obeys the effective increment. They also check that the count only ever falls by one unit, that the bus stays quiet while done or an error is flagged, and that irq never rises without a flag. Only the bench scenarios can show that the right bytes land at the right destination addresses for each mix of sizes. The same holds for how auto-align picks its side, which setups are rejected, how many units a peripheral pulse, a start write or both together produce, and that writes made while busy are dropped.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    // register select codes
    localparam logic [2:0] RA_SRC = 3'd0;
    localparam logic [2:0] RA_DST = 3'd1;
    localparam logic [2:0] RA_CNT = 3'd2;
    localparam logic [2:0] RA_CTL = 3'd3;
    localparam logic [2:0] RA_STS = 3'd4;

    // control word bit positions
    localparam int CB_IE    = 31;
    localparam int CB_ERQ   = 30;
    localparam int CB_CS    = 29;
    localparam int CB_AA    = 28;
    localparam int CB_SINC  = 22;
    localparam int CB_SSZ   = 20;
    localparam int CB_DINC  = 19;
    localparam int CB_DSZ   = 17;
    localparam int CB_START = 16;

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

    typedef struct packed {
        logic       ie;
        logic       erq;
        logic       cs;
        logic       aa;
        logic       sinc;
        logic [1:0] ssize;
        logic       dinc;
        logic [1:0] dsize;
    } ctrl_t;

    // access size code to byte count, 0 for the reserved code
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd4;
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [1:0] bytes_log2(input logic [2:0] n);
        case (n)
            3'd2:    return 2'd1;
            3'd4:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_xfer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [1:0]       ssize,
    input  logic [1:0]       dsize,
    input  logic             aa,
    input  logic             sinc,
    input  logic             dinc,
    input  logic [1:0]       sar_lo,
    input  logic [1:0]       dar_lo,
    input  logic [CNT_W-1:0] bcr,
    output logic [2:0]       src_bytes,
    output logic [2:0]       dst_bytes,
    output logic [2:0]       unit_bytes,
    output logic [2:0]       n_rd,
    output logic [2:0]       n_wr,
    output logic             sinc_eff,
    output logic             dinc_eff,
    output logic             cfg_err
);
    logic src_side;
    logic rsvd;
    logic cnt_bad;
    logic mis_bad;

    always_comb begin
        src_bytes  = size_bytes(ssize);
        dst_bytes  = size_bytes(dsize);
        unit_bytes = (src_bytes > dst_bytes) ? src_bytes : dst_bytes;
        n_rd       = unit_bytes >> bytes_log2(src_bytes);
        n_wr       = unit_bytes >> bytes_log2(dst_bytes);
        // auto-align prefers the source side when it is not the narrower one
        src_side   = (src_bytes >= dst_bytes);
        sinc_eff   = sinc | (aa & src_side);
        dinc_eff   = dinc | (aa & ~src_side);
        rsvd       = (src_bytes == 3'd0) || (dst_bytes == 3'd0);
        cnt_bad    = (bcr == '0) ||
                     ((bcr & (CNT_W'(unit_bytes) - CNT_W'(1))) != '0);
        mis_bad    = !aa && (((sar_lo & (src_bytes[1:0] - 2'd1)) != 2'd0) ||
                             ((dar_lo & (dst_bytes[1:0] - 2'd1)) != 2'd0));
        cfg_err    = rsvd || cnt_bad || mis_bad;
    end

endmodule

// File: rtl/dma_byte_lane.sv
module dma_byte_lane (
    input  logic [31:0] buf_in,
    input  logic [31:0] rdata,
    input  logic [1:0]  rd_off,
    input  logic [2:0]  rd_len,
    input  logic [1:0]  wr_off,
    output logic [31:0] buf_out,
    output logic [31:0] wdata
);
    // merge a read beat into the unit buffer at its byte offset
    always_comb begin
        buf_out = buf_in;
        for (int b = 0; b < 4; b++) begin
            int rel;
            rel = b - int'(rd_off);
            if (rel >= 0 && rel < int'(rd_len)) begin
                buf_out[b*8 +: 8] = rdata[rel[1:0]*8 +: 8];
            end
        end
        wdata = buf_in >> {wr_off, 3'b000};
    end

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              irq
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] sar;
        logic [ADDR_W-1:0] dar;
        logic [CNT_W-1:0]  bcr;
        ctrl_t             ctrl;
        logic              done;
        logic              ce;
        logic [31:0]       dbuf;
        logic [1:0]        rd_idx;
        logic [1:0]        wr_idx;
    } chan_t;

    chan_t st_q, st_d;

    logic             idle;
    logic             busy;
    logic             wr_ok;
    logic             ctrl_wr;
    logic             start_req;
    logic             req;
    ctrl_t            ctrl_new;
    ctrl_t            ctrl_use;
    logic [2:0]       src_bytes, dst_bytes, unit_bytes, n_rd, n_wr;
    logic             sinc_eff, dinc_eff, cfg_err;
    logic [1:0]       rd_off, wr_off;
    logic [31:0]      buf_merged, lane_wdata;
    logic [CNT_W-1:0] bcr_next;
    logic [ADDR_W-1:0] sar_cur;

    assign idle    = (st_q.ph == PH_IDLE);
    assign busy    = !idle;
    assign sar_cur = st_q.sar;

    always_comb begin
        ctrl_new.ie    = reg_wdata[CB_IE];
        ctrl_new.erq   = reg_wdata[CB_ERQ];
        ctrl_new.cs    = reg_wdata[CB_CS];
        ctrl_new.aa    = reg_wdata[CB_AA];
        ctrl_new.sinc  = reg_wdata[CB_SINC];
        ctrl_new.ssize = reg_wdata[CB_SSZ +: 2];
        ctrl_new.dinc  = reg_wdata[CB_DINC];
        ctrl_new.dsize = reg_wdata[CB_DSZ +: 2];
    end

    assign wr_ok     = reg_we && idle;
    assign ctrl_wr   = wr_ok && (reg_addr == RA_CTL);
    assign ctrl_use  = ctrl_wr ? ctrl_new : st_q.ctrl;
    assign start_req = ctrl_wr && reg_wdata[CB_START];
    // start and a peripheral pulse in one cycle collapse into one request
    assign req       = start_req || (ctrl_use.erq && periph_req);

    dma_cfg_check #(.CNT_W(CNT_W)) i_cfg (
        .ssize     (ctrl_use.ssize),
        .dsize     (ctrl_use.dsize),
        .aa        (ctrl_use.aa),
        .sinc      (ctrl_use.sinc),
        .dinc      (ctrl_use.dinc),
        .sar_lo    (st_q.sar[1:0]),
        .dar_lo    (st_q.dar[1:0]),
        .bcr       (st_q.bcr),
        .src_bytes (src_bytes),
        .dst_bytes (dst_bytes),
        .unit_bytes(unit_bytes),
        .n_rd      (n_rd),
        .n_wr      (n_wr),
        .sinc_eff  (sinc_eff),
        .dinc_eff  (dinc_eff),
        .cfg_err   (cfg_err)
    );

    assign rd_off = 2'(32'(st_q.rd_idx) * 32'(src_bytes));
    assign wr_off = 2'(32'(st_q.wr_idx) * 32'(dst_bytes));

    dma_byte_lane i_lane (
        .buf_in (st_q.dbuf),
        .rdata  (bus_rdata),
        .rd_off (rd_off),
        .rd_len (src_bytes),
        .wr_off (wr_off),
        .buf_out(buf_merged),
        .wdata  (lane_wdata)
    );

    assign bcr_next = st_q.bcr - CNT_W'(unit_bytes);

    always_comb begin
        st_d      = st_q;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_size  = 2'b00;
        bus_wdata = '0;

        if (wr_ok) begin
            case (reg_addr)
                RA_SRC:  st_d.sar  = reg_wdata[ADDR_W-1:0];
                RA_DST:  st_d.dar  = reg_wdata[ADDR_W-1:0];
                RA_CNT:  st_d.bcr  = reg_wdata[CNT_W-1:0];
                RA_CTL:  st_d.ctrl = ctrl_new;
                default: ;
            endcase
        end
        if (reg_we && (reg_addr == RA_STS) && reg_wdata[0]) begin
            st_d.done = 1'b0;
            st_d.ce   = 1'b0;
        end

        case (st_q.ph)
            PH_IDLE: begin
                if (req && !st_q.done && !st_q.ce) begin
                    if (cfg_err) begin
                        st_d.ce = 1'b1;
                    end else begin
                        st_d.ph     = PH_READ;
                        st_d.rd_idx = '0;
                        st_d.wr_idx = '0;
                    end
                end
            end
            PH_READ: begin
                bus_req  = 1'b1;
                bus_addr = st_q.sar;
                bus_size = st_q.ctrl.ssize;
                if (bus_ack) begin
                    st_d.dbuf = buf_merged;
                    if (sinc_eff) st_d.sar = st_q.sar + ADDR_W'(src_bytes);
                    if (3'(st_q.rd_idx) == n_rd - 3'd1) begin
                        st_d.ph     = PH_WRITE;
                        st_d.wr_idx = '0;
                    end else begin
                        st_d.rd_idx = st_q.rd_idx + 2'd1;
                    end
                end
            end
            PH_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = st_q.dar;
                bus_size  = st_q.ctrl.dsize;
                bus_wdata = lane_wdata;
                if (bus_ack) begin
                    if (dinc_eff) st_d.dar = st_q.dar + ADDR_W'(dst_bytes);
                    if (3'(st_q.wr_idx) == n_wr - 3'd1) begin
                        st_d.bcr    = bcr_next;
                        st_d.rd_idx = '0;
                        st_d.wr_idx = '0;
                        if (bcr_next == '0) begin
                            st_d.done = 1'b1;
                            st_d.ph   = PH_IDLE;
                        end else if (st_q.ctrl.cs) begin
                            st_d.ph = PH_IDLE;
                        end else begin
                            st_d.ph = PH_READ;
                        end
                    end else begin
                        st_d.wr_idx = st_q.wr_idx + 2'd1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SRC: reg_rdata = 32'(st_q.sar);
            RA_DST: reg_rdata = 32'(st_q.dar);
            RA_CNT: reg_rdata = 32'(st_q.bcr);
            RA_CTL: begin
                reg_rdata[CB_IE]        = st_q.ctrl.ie;
                reg_rdata[CB_ERQ]       = st_q.ctrl.erq;
                reg_rdata[CB_CS]        = st_q.ctrl.cs;
                reg_rdata[CB_AA]        = st_q.ctrl.aa;
                reg_rdata[CB_SINC]      = st_q.ctrl.sinc;
                reg_rdata[CB_SSZ +: 2]  = st_q.ctrl.ssize;
                reg_rdata[CB_DINC]      = st_q.ctrl.dinc;
                reg_rdata[CB_DSZ +: 2]  = st_q.ctrl.dsize;
            end
            RA_STS: reg_rdata = {29'd0, busy, st_q.ce, st_q.done};
            default: ;
        endcase
    end

    assign irq = st_q.ctrl.ie & (st_q.done | st_q.ce);

endmodule

// File: rtl/dma_xfer_chan_chk.sv
module dma_xfer_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              busy,
    input logic              done,
    input logic              ce,
    input logic [ADDR_W-1:0] sar,
    input logic [CNT_W-1:0]  bcr,
    input logic              sinc_eff,
    input logic [2:0]        src_bytes,
    input logic [2:0]        unit_bytes,
    input logic [1:0]        ssize
);
    // R14
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_size) && $stable(bus_wdata));

    // R12
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || ce) |-> !bus_req);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && (bcr != $past(bcr)) |-> ($past(bcr) - bcr) == CNT_W'($past(unit_bytes)));

    // R3
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_ack && !sinc_eff |=> $stable(sar));

    // R3
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_ack && sinc_eff |=> sar == $past(sar) + ADDR_W'($past(src_bytes)));

    // R2
    rd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_size == ssize);

    // R13
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done || ce));

endmodule

bind dma_xfer_chan dma_xfer_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .busy      (busy),
    .done      (st_q.done),
    .ce        (st_q.ce),
    .sar       (sar_cur),
    .bcr       (st_q.bcr),
    .sinc_eff  (sinc_eff),
    .src_bytes (src_bytes),
    .unit_bytes(unit_bytes),
    .ssize     (st_q.ctrl.ssize)
);

// File: tb/test_dma_xfer_chan.sv
module test_dma_xfer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        irq;

    int total = 0;
    int bad   = 0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [3:0] lfsr = 4'b1001;
    logic       mon_on = 1'b0;
    logic [1:0] exp_ss = '0, exp_ds = '0;
    int         size_bad = 0;

    always #10 clk = ~clk;

    dma_xfer_chan i_dma_xfer_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
    );

    function automatic int sbytes(input int code);
        return (code == 0) ? 4 : (code == 1) ? 1 : (code == 2) ? 2 : 0;
    endfunction

    // memory with pseudo-random wait states
    assign bus_ack = bus_req && lfsr[0];
    always @(posedge clk) lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};

    always_comb begin
        for (int k = 0; k < 4; k++) bus_rdata[k*8 +: 8] = mem[8'(bus_addr[7:0] + 8'(k))];
    end

    always @(posedge clk) begin
        if (bus_req && bus_we && bus_ack) begin
            for (int k = 0; k < sbytes(int'(bus_size)); k++)
                mem[8'(bus_addr[7:0] + 8'(k))] = bus_wdata[k*8 +: 8];
        end
    end

    always @(negedge clk) begin
        if (mon_on && bus_req) begin
            if ((!bus_we && bus_size != exp_ss) || (bus_we && bus_size != exp_ds)) size_bad++;
        end
    end

    function automatic logic [31:0] mkctl(input int ie, input int erq, input int cs, input int aa,
                                          input int si, input int ss, input int di, input int ds,
                                          input int st);
        return (32'(ie) << 31) | (32'(erq) << 30) | (32'(cs) << 29) | (32'(aa) << 28) |
               (32'(si) << 22) | (32'(ss) << 20) | (32'(di) << 19) | (32'(ds) << 17) |
               (32'(st) << 16);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd(3'd4, s);
            if (!s[2]) break;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    endtask

    // stimulus table: addresses, count, sizes (0 long,1 byte,2 word,3 reserved), flags, expected error
    localparam int NV = 10;
    localparam int V_SRC [NV] = '{'h10, 'h20, 'h31, 'h40, 'h52, 'h60, 'h10, 'h20, 'h40, 'h40};
    localparam int V_DST [NV] = '{'h80, 'h90, 'hA0, 'hB0, 'hC0, 'hD1, 'h80, 'h90, 'hB1, 'hB0};
    localparam int V_CNT [NV] = '{8, 8, 8, 6, 8, 4, 4, 6, 4, 0};
    localparam int V_SS  [NV] = '{1, 0, 1, 2, 0, 1, 3, 0, 2, 2};
    localparam int V_DS  [NV] = '{1, 1, 0, 2, 1, 2, 1, 0, 2, 2};
    localparam int V_SI  [NV] = '{1, 1, 1, 0, 0, 1, 1, 1, 1, 1};
    localparam int V_DI  [NV] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
    localparam int V_AA  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0};
    localparam int V_IE  [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1", "reset register", d, 32'd0);
        end
        chk("R1", "reset irq", {31'd0, irq}, 32'd0);
        chk("R1", "reset bus_req", {31'd0, bus_req}, 32'd0);
        wr(3'd3, 32'hFFFE_FFFF);
        rd(3'd3, d);
        chk("R1", "control readback masks reserved bits", d, 32'hF07E_0000);
        wr(3'd3, 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int sb, db, unit, nrd, nwr, sa, da, left, si_e, di_e, diff;
            logic [7:0] ub [4];
            string rq;
            fill_mem();
            for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
            sb = sbytes(V_SS[v]); db = sbytes(V_DS[v]);
            unit = (sb > db) ? sb : db;
            sa = V_SRC[v]; da = V_DST[v];
            si_e = V_SI[v]; di_e = V_DI[v];
            if (V_AA[v] != 0) begin
                if (sb >= db) si_e = 1; else di_e = 1;
            end
            if (V_ERR[v] == 0) begin
                nrd = unit / sb; nwr = unit / db; left = V_CNT[v];
                while (left > 0) begin
                    for (int r = 0; r < nrd; r++) begin
                        for (int b = 0; b < sb; b++) ub[r*sb + b] = exp_mem[(sa + b) & 255];
                        if (si_e != 0) sa += sb;
                    end
                    for (int w = 0; w < nwr; w++) begin
                        for (int b = 0; b < db; b++) exp_mem[(da + b) & 255] = ub[w*db + b];
                        if (di_e != 0) da += db;
                    end
                    left -= unit;
                end
            end
            rq = (V_AA[v] != 0) ? "R10" : (V_ERR[v] != 0) ? "R11" : "R5";
            wr(3'd4, 32'd1);
            wr(3'd0, 32'(V_SRC[v]));
            wr(3'd1, 32'(V_DST[v]));
            wr(3'd2, 32'(V_CNT[v]));
            exp_ss = 2'(V_SS[v]); exp_ds = 2'(V_DS[v]);
            size_bad = 0; mon_on = 1'b1;
            wr(3'd3, mkctl(V_IE[v], 0, 0, V_AA[v], V_SI[v], V_SS[v], V_DI[v], V_DS[v], 1));
            wait_idle();
            mon_on = 1'b0;
            rd(3'd4, d);
            chk((V_ERR[v] != 0) ? "R11" : "R6", "status flags", d,
                (V_ERR[v] != 0) ? 32'd2 : 32'd1);
            chk("R13", "irq level", {31'd0, irq}, 32'(V_IE[v]));
            rd(3'd2, d);
            chk(rq, "final count", d, (V_ERR[v] != 0) ? 32'(V_CNT[v]) : 32'd0);
            rd(3'd0, d);
            chk((V_AA[v] != 0) ? "R10" : "R3", "final source address", d, 32'(sa));
            rd(3'd1, d);
            chk((V_AA[v] != 0) ? "R10" : "R4", "final destination address", d, 32'(da));
            diff = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) diff++;
            chk(rq, "memory bytes differing", 32'(diff), 32'd0);
            chk("R2", "bus size codes", 32'(size_bad), 32'd0);
        end

        // cycle steal driven by the peripheral line
        fill_mem();
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h10); wr(3'd1, 32'hE0); wr(3'd2, 32'd3);
        wr(3'd3, mkctl(0, 1, 1, 0, 1, 1, 1, 1, 0));
        pulse_req(); wait_idle();
        rd(3'd2, d); chk("R7", "count after first pulse", d, 32'd2);
        rd(3'd4, d); chk("R7", "not done after first pulse", d, 32'd0);
        pulse_req(); wait_idle();
        rd(3'd2, d); chk("R7", "count after second pulse", d, 32'd1);
        pulse_req(); wait_idle();
        rd(3'd2, d); chk("R7", "count after third pulse", d, 32'd0);
        rd(3'd4, d); chk("R7", "done after last unit", d, 32'd1);

        // peripheral line ignored when disabled, start still works
        wr(3'd4, 32'd1);
        wr(3'd2, 32'd3);
        wr(3'd3, mkctl(0, 0, 1, 0, 1, 1, 1, 1, 0));
        pulse_req();
        repeat (10) @(negedge clk);
        rd(3'd2, d); chk("R8", "count with request disabled", d, 32'd3);
        wr(3'd3, mkctl(0, 0, 1, 0, 1, 1, 1, 1, 1));
        wait_idle();
        rd(3'd2, d); chk("R8", "count after start", d, 32'd2);

        // start and peripheral request in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = mkctl(0, 1, 1, 0, 1, 1, 1, 1, 1);
        periph_req = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; periph_req = 1'b0;
        wait_idle();
        rd(3'd2, d); chk("R9", "count after merged request", d, 32'd1);

        // done blocks further requests until cleared
        wr(3'd3, mkctl(0, 0, 1, 0, 1, 1, 1, 1, 1));
        wait_idle();
        rd(3'd4, d); chk("R6", "done at zero count", d, 32'd1);
        chk("R13", "irq stays low with enable off", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'd2);
        wr(3'd3, mkctl(0, 0, 1, 0, 1, 1, 1, 1, 1));
        repeat (10) @(negedge clk);
        rd(3'd2, d); chk("R12", "count held while done", d, 32'd2);
        wr(3'd4, 32'd1);
        rd(3'd4, d); chk("R12", "status cleared", d, 32'd0);
        wr(3'd3, mkctl(0, 0, 1, 0, 1, 1, 1, 1, 1));
        wait_idle();
        rd(3'd2, d); chk("R12", "count after clear and start", d, 32'd1);

        // register write while busy is dropped
        fill_mem();
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h10); wr(3'd1, 32'h80); wr(3'd2, 32'd8);
        wr(3'd3, mkctl(0, 0, 0, 0, 1, 1, 1, 1, 1));
        wr(3'd0, 32'h00);
        wait_idle();
        rd(3'd0, d); chk("R14", "source address unaffected by busy write", d, 32'h18);
        rd(3'd4, d); chk("R14", "run completed", d, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule